// File: doc/BRIEF.md
# Masked Calendar Alarm with Repeat Counter

This block watches the calendar time produced by a separate timekeeping unit and raises a one-cycle alarm pulse when the time agrees with a stored alarm setting. A 4-bit mask code chooses which time digits take part in the comparison. The mask therefore sets how often the alarm can fire, from every half-second tick up to once a year. The comparison runs only on the half-second tick, so one matching instant gives at most one event.

An 8-bit repeat counter sets how many events occur before the block disarms itself. Each event lowers the counter by one. An event that arrives while the counter is already zero is the final one, and the block then clears its armed state. In chime mode the counter wraps from zero to all ones instead, and the alarm keeps repeating for as long as chime mode is on. The alarm setting and the mask are locked while the block is armed. The repeat count, the chime mode and the armed state can be written at any time through plain strobes. No interface carries a data stream, so every pin is a level or a single-cycle strobe. There is no back-pressure.

Top module: `cal_alarm`

## Requirements
- R1: After reset `alarm_pulse`, `armed` and `rep_left` are 0, and chime mode is off.
- R2: Each digit pair (seconds, minutes, hours, day, month) is a BCD byte, with the tens digit in bits 7:4 and the units digit in bits 3:0. The weekday is 3 bits and the half flag is 1 bit. The mask codes select these fields for comparison:
  - 0: no field (every tick)
  - 1: half flag
  - 2: code 1 plus the seconds units digit
  - 3: code 1 plus the full seconds byte
  - 4: code 3 plus the minutes units digit
  - 5: code 3 plus the full minutes byte
  - 6: code 5 plus hours
  - 7: code 6 plus weekday
  - 8: code 6 plus day
  - 9: code 8 plus month
- R3: Mask codes 10 to 15 never produce an event.
- R4: An event occurs only at a clock edge where `half_tick` is 1, the block is armed and the selected fields match. `alarm_pulse` is 1 for exactly the cycle that follows that edge.
- R5: An event with a nonzero count lowers `rep_left` by one and leaves the block armed.
- R6: An event with `rep_left` at 0 and chime mode off clears `armed`. Loading FFh therefore yields 256 events in total, and loading 0 yields exactly one.
- R7: An event with `rep_left` at 0 and chime mode on sets `rep_left` to FFh and keeps the block armed.
- R8: `rep_wr` loads `rep_val` into the counter at any time. In the same cycle, this load takes priority over the decrement caused by an event.
- R9: `set_wr` loads the alarm digits and the mask only while the block is disarmed. While the block is armed, a `set_wr` strobe is ignored.
- R10: `arm_wr` writes `arm_val` into the armed state. In the same cycle, this write takes priority over the automatic disarm.
- R11: `chime_wr` writes `chime_val` into chime mode at any time. An event uses the chime mode that was in effect before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | Half-second tick; comparison strobe |
| now_half | input | 1 | Current half-second flag |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 3 | Current weekday |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| set_half | input | 1 | Alarm half-second flag |
| set_sec | input | 8 | Alarm seconds, BCD |
| set_min | input | 8 | Alarm minutes, BCD |
| set_hour | input | 8 | Alarm hours, BCD |
| set_wday | input | 3 | Alarm weekday |
| set_day | input | 8 | Alarm day, BCD |
| set_mon | input | 8 | Alarm month, BCD |
| set_mask | input | 4 | Mask code to store |
| set_wr | input | 1 | Strobe that stores the alarm digits and mask |
| rep_val | input | 8 | Repeat count to load |
| rep_wr | input | 1 | Repeat count load strobe |
| chime_val | input | 1 | Chime mode value |
| chime_wr | input | 1 | Chime mode write strobe |
| arm_val | input | 1 | Armed state value |
| arm_wr | input | 1 | Armed state write strobe |
| alarm_pulse | output | 1 | One-cycle alarm event pulse |
| armed | output | 1 | Current armed state |
| rep_left | output | 8 | Remaining repeat count |

## Verification
The hardest states to reach are those that need many events or an exact collision. Running the counter down from FFh to the automatic disarm needs 256 events. The bench reaches this quickly by choosing mask 0 and holding the tick high, so that an event fires on every clock. The yearly and monthly codes need month and day agreement, which real time would take far too long to produce. The bench therefore drives the time digits directly, disturbing one field at a time against every mask code. It also puts strobes in the same cycle as an event, to show which write wins.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int DIG_W     = 8;
  localparam int WDAY_W    = 3;
  localparam int MASK_W    = 4;
  localparam int LANES     = 9;
  localparam int WEEK_LANE = 6;

  localparam logic [MASK_W-1:0] MASK_WEEK = MASK_W'(7);
  localparam logic [MASK_W-1:0] MASK_TOP  = MASK_W'(9);

  typedef struct packed {
    logic              half;
    logic [DIG_W-1:0]  sec;
    logic [DIG_W-1:0]  min;
    logic [DIG_W-1:0]  hour;
    logic [WDAY_W-1:0] wday;
    logic [DIG_W-1:0]  day;
    logic [DIG_W-1:0]  mon;
  } cal_t;

  // smallest mask code at which a lane joins the compare
  function automatic logic [MASK_W-1:0] lane_floor(input int idx);
    logic [MASK_W-1:0] f;
    case (idx)
      0: f = MASK_W'(1);
      1: f = MASK_W'(2);
      2: f = MASK_W'(3);
      3: f = MASK_W'(4);
      4: f = MASK_W'(5);
      5: f = MASK_W'(6);
      6: f = MASK_W'(7);
      7: f = MASK_W'(8);
      default: f = MASK_W'(9);
    endcase
    return f;
  endfunction

  function automatic logic lane_same(input cal_t a, input cal_t b, input int idx);
    logic s;
    case (idx)
      0: s = (a.half == b.half);
      1: s = (a.sec[3:0] == b.sec[3:0]);
      2: s = (a.sec[DIG_W-1:4] == b.sec[DIG_W-1:4]);
      3: s = (a.min[3:0] == b.min[3:0]);
      4: s = (a.min[DIG_W-1:4] == b.min[DIG_W-1:4]);
      5: s = (a.hour == b.hour);
      6: s = (a.wday == b.wday);
      7: s = (a.day == b.day);
      default: s = (a.mon == b.mon);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  cal_t              now_i,
  input  cal_t              ref_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);

  logic [LANES-1:0] same;
  logic [LANES-1:0] need;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign same[g] = lane_same(now_i, ref_i, g);
    if (g == WEEK_LANE) begin : g_exact
      assign need[g] = (mask_i == MASK_WEEK);
    end else begin : g_floor
      assign need[g] = (mask_i >= lane_floor(g));
    end
  end

  assign hit_o = (mask_i <= MASK_TOP) && ((same | ~need) == {LANES{1'b1}});

endmodule

// File: rtl/cal_alarm_repeat.sv
module cal_alarm_repeat #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_i,
  input  logic             chime_val_i,
  input  logic             chime_wr_i,
  input  logic             arm_val_i,
  input  logic             arm_wr_i,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             chime_q
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  logic at_zero;
  logic last_shot;
  logic [CNT_W-1:0] cnt_next;

  assign at_zero   = (cnt_q == CNT_ZERO);
  assign last_shot = fire_i && at_zero && !chime_q;

  always_comb begin
    cnt_next = cnt_q;
    if (load_i)             cnt_next = load_val_i;
    else if (fire_i) begin
      if (!at_zero)         cnt_next = cnt_q - 1'b1;
      else if (chime_q)     cnt_next = CNT_FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnt_q   <= CNT_ZERO;
      chime_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      if (chime_wr_i) chime_q <= chime_val_i;
      if (arm_wr_i)        en_q <= arm_val_i;
      else if (last_shot)  en_q <= 1'b0;
    end
  end

  // R5: count steps down by one per event
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !load_i && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: chime wraps zero to full and stays armed
  a_r7_chime_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !load_i && !arm_wr_i && at_zero && chime_q) |=> (cnt_q == CNT_FULL && en_q));

  // R6: final event disarms
  a_r6_last_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !arm_wr_i && at_zero && !chime_q) |=> !en_q);

  // R10: an arm write lands
  a_r10_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr_i |=> (en_q == $past(arm_val_i)));

  // R8: a load lands
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              now_half,
  input  logic [DIG_W-1:0]  now_sec,
  input  logic [DIG_W-1:0]  now_min,
  input  logic [DIG_W-1:0]  now_hour,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic [DIG_W-1:0]  now_day,
  input  logic [DIG_W-1:0]  now_mon,
  input  logic              set_half,
  input  logic [DIG_W-1:0]  set_sec,
  input  logic [DIG_W-1:0]  set_min,
  input  logic [DIG_W-1:0]  set_hour,
  input  logic [WDAY_W-1:0] set_wday,
  input  logic [DIG_W-1:0]  set_day,
  input  logic [DIG_W-1:0]  set_mon,
  input  logic [MASK_W-1:0] set_mask,
  input  logic              set_wr,
  input  logic [CNT_W-1:0]  rep_val,
  input  logic              rep_wr,
  input  logic              chime_val,
  input  logic              chime_wr,
  input  logic              arm_val,
  input  logic              arm_wr,
  output logic              alarm_pulse,
  output logic              armed,
  output logic [CNT_W-1:0]  rep_left
);

  cal_t              now_c;
  cal_t              set_c;
  cal_t              ref_q;
  logic [MASK_W-1:0] mask_q;
  logic              hit;
  logic              fire;
  logic              en_q;
  logic              chime_q;
  logic              pulse_q;

  assign now_c = '{half: now_half, sec: now_sec, min: now_min, hour: now_hour,
                   wday: now_wday, day: now_day, mon: now_mon};
  assign set_c = '{half: set_half, sec: set_sec, min: set_min, hour: set_hour,
                   wday: set_wday, day: set_day, mon: set_mon};

  // setting store, locked while armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      mask_q <= '0;
    end else if (set_wr && !en_q) begin
      ref_q  <= set_c;
      mask_q <= set_mask;
    end
  end

  cal_alarm_match i_match (
    .now_i  (now_c),
    .ref_i  (ref_q),
    .mask_i (mask_q),
    .hit_o  (hit)
  );

  assign fire = en_q && half_tick && hit;

  cal_alarm_repeat #(.CNT_W(CNT_W)) i_repeat (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire),
    .load_val_i  (rep_val),
    .load_i      (rep_wr),
    .chime_val_i (chime_val),
    .chime_wr_i  (chime_wr),
    .arm_val_i   (arm_val),
    .arm_wr_i    (arm_wr),
    .en_q        (en_q),
    .cnt_q       (rep_left),
    .chime_q     (chime_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  assign alarm_pulse = pulse_q;
  assign armed       = en_q;

  // R9: setting frozen while armed
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && set_wr) |=> ($stable(ref_q) && $stable(mask_q)));

  // R4: a pulse follows a sampled tick
  a_r4_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> ($past(half_tick) && $past(en_q)));

  // R3: reserved codes stay silent
  a_r3_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> ($past(mask_q) <= MASK_TOP));

  // R6: disarm only by write or final event
  a_r6_disarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(arm_wr) || (alarm_pulse && $past(rep_left) == '0)));

endmodule

// File: tb/test_cal_alarm.sv
module test_cal_alarm;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic now_half = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0, now_mon = '0;
  logic [2:0] now_wday = '0;
  logic set_half = 1'b0;
  logic [7:0] set_sec = '0, set_min = '0, set_hour = '0, set_day = '0, set_mon = '0;
  logic [2:0] set_wday = '0;
  logic [3:0] set_mask = '0;
  logic set_wr = 1'b0;
  logic [7:0] rep_val = '0;
  logic rep_wr = 1'b0;
  logic chime_val = 1'b0, chime_wr = 1'b0;
  logic arm_val = 1'b0, arm_wr = 1'b0;
  logic alarm_pulse, armed;
  logic [7:0] rep_left;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cal_alarm i_cal_alarm (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .now_half(now_half), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_day(now_day), .now_mon(now_mon),
    .set_half(set_half), .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour),
    .set_wday(set_wday), .set_day(set_day), .set_mon(set_mon),
    .set_mask(set_mask), .set_wr(set_wr), .rep_val(rep_val), .rep_wr(rep_wr),
    .chime_val(chime_val), .chime_wr(chime_wr), .arm_val(arm_val), .arm_wr(arm_wr),
    .alarm_pulse(alarm_pulse), .armed(armed), .rep_left(rep_left)
  );

  // behavioural reference
  function automatic bit ref_hit(int m, bit h, int s, int mi, int hr, int wd, int d, int mo,
                                 bit rh, int rs, int rmi, int rhr, int rwd, int rd, int rmo);
    bit ok = 1;
    if (m > 9) return 0;
    if (m >= 1 && h != rh) ok = 0;
    if (m >= 2 && (s % 16) != (rs % 16)) ok = 0;
    if (m >= 3 && (s / 16) != (rs / 16)) ok = 0;
    if (m >= 4 && (mi % 16) != (rmi % 16)) ok = 0;
    if (m >= 5 && (mi / 16) != (rmi / 16)) ok = 0;
    if (m >= 6 && hr != rhr) ok = 0;
    if (m == 7 && wd != rwd) ok = 0;
    if (m >= 8 && d != rd) ok = 0;
    if (m == 9 && mo != rmo) ok = 0;
    return ok;
  endfunction

  bit m_en, m_chime, m_irq, m_rh;
  int m_cnt, m_mask, m_rs, m_rmi, m_rhr, m_rwd, m_rd, m_rmo;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_chime = 0; m_irq = 0; m_cnt = 0; m_mask = 0;
      m_rh = 0; m_rs = 0; m_rmi = 0; m_rhr = 0; m_rwd = 0; m_rd = 0; m_rmo = 0;
    end else begin
      bit fire, old_chime, old_en;
      int old_cnt;
      fire = m_en && half_tick && ref_hit(m_mask, now_half, now_sec, now_min, now_hour,
               now_wday, now_day, now_mon, m_rh, m_rs, m_rmi, m_rhr, m_rwd, m_rd, m_rmo);
      old_chime = m_chime; old_cnt = m_cnt; old_en = m_en;
      if (chime_wr) m_chime = chime_val;
      if (rep_wr) m_cnt = rep_val;
      else if (fire) begin
        if (old_cnt > 0) m_cnt = old_cnt - 1;
        else if (old_chime) m_cnt = 255;
      end
      if (set_wr && !old_en) begin
        m_rh = set_half; m_rs = set_sec; m_rmi = set_min; m_rhr = set_hour;
        m_rwd = set_wday; m_rd = set_day; m_rmo = set_mon; m_mask = set_mask;
      end
      if (arm_wr) m_en = arm_val;
      else if (fire && old_cnt == 0 && !old_chime) m_en = 0;
      m_irq = fire;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    chk(alarm_pulse == m_irq, "R4 pulse vs model", alarm_pulse, m_irq);
    chk(armed == m_en, "R6 armed vs model", armed, m_en);
    chk(rep_left == m_cnt, "R5 count vs model", rep_left, m_cnt);
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_set(bit h, logic [7:0] s, logic [7:0] mi, logic [7:0] hr, logic [2:0] wd,
                        logic [7:0] d, logic [7:0] mo, logic [3:0] m);
    @(negedge clk);
    set_half = h; set_sec = s; set_min = mi; set_hour = hr; set_wday = wd;
    set_day = d; set_mon = mo; set_mask = m; set_wr = 1;
    @(negedge clk); set_wr = 0;
  endtask

  task automatic do_now(bit h, logic [7:0] s, logic [7:0] mi, logic [7:0] hr, logic [2:0] wd,
                        logic [7:0] d, logic [7:0] mo);
    now_half = h; now_sec = s; now_min = mi; now_hour = hr; now_wday = wd;
    now_day = d; now_mon = mo;
  endtask

  task automatic do_arm(bit v);
    @(negedge clk); arm_val = v; arm_wr = 1; @(negedge clk); arm_wr = 0;
  endtask
  task automatic do_rep(logic [7:0] v);
    @(negedge clk); rep_val = v; rep_wr = 1; @(negedge clk); rep_wr = 0;
  endtask
  task automatic do_chime(bit v);
    @(negedge clk); chime_val = v; chime_wr = 1; @(negedge clk); chime_wr = 0;
  endtask
  // returns at the negedge where the resulting pulse is visible
  task automatic tick1();
    @(negedge clk); half_tick = 1; @(negedge clk); half_tick = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) cyc();
    // R1 reset state
    chk(alarm_pulse == 0, "R1 pulse", alarm_pulse, 0);
    chk(armed == 0, "R1 armed", armed, 0);
    chk(rep_left == 0, "R1 count", rep_left, 0);
    rst_n = 1;
    cyc();

    // R2 / R3 mask sweep, one field disturbed at a time
    for (int m = 0; m < 16; m++) begin
      for (int f = 0; f < 10; f++) begin
        bit h; logic [7:0] s, mi, hr, d, mo; logic [2:0] wd; bit e;
        h = 1; s = 8'h45; mi = 8'h37; hr = 8'h12; wd = 3'd3; d = 8'h21; mo = 8'h06;
        do_arm(0);
        do_set(1, 8'h45, 8'h37, 8'h12, 3'd3, 8'h21, 8'h06, 4'(m));
        do_chime(1);
        do_rep(0);
        do_arm(1);
        case (f)
          0: h = 0;
          1: s = 8'h46;
          2: s = 8'h55;
          3: mi = 8'h38;
          4: mi = 8'h47;
          5: hr = 8'h13;
          6: wd = 3'd4;
          7: d = 8'h22;
          8: mo = 8'h07;
          default: ;
        endcase
        do_now(h, s, mi, hr, wd, d, mo);
        e = ref_hit(m, h, s, mi, hr, wd, d, mo, 1, 8'h45, 8'h37, 8'h12, 3, 8'h21, 8'h06);
        tick1();
        if (m > 9) chk(alarm_pulse == 0, "R3 reserved mask", alarm_pulse, 0);
        else       chk(alarm_pulse == e, "R2 mask field select", alarm_pulse, e);
      end
    end

    // R4 no tick, no event; held tick gives one event per clock
    do_arm(0);
    do_set(0, 0, 0, 0, 0, 0, 0, 4'd0);
    do_chime(1); do_rep(0); do_arm(1);
    repeat (4) begin cyc(); chk(alarm_pulse == 0, "R4 idle without tick", alarm_pulse, 0); end
    @(negedge clk); half_tick = 1;
    repeat (3) begin @(negedge clk); chk(alarm_pulse == 1, "R4 held tick", alarm_pulse, 1); end
    half_tick = 0;
    cyc(); chk(alarm_pulse == 0, "R4 pulse drops", alarm_pulse, 0);

    // R11 reset clears chime; then R6 single shot
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    do_set(0, 0, 0, 0, 0, 0, 0, 4'd0);
    do_rep(0); do_arm(1);
    tick1();
    chk(alarm_pulse == 1, "R6 single shot fires", alarm_pulse, 1);
    chk(armed == 0, "R11 chime cleared by reset, disarms", armed, 0);
    tick1();
    chk(alarm_pulse == 0, "R6 no second shot", alarm_pulse, 0);

    // R5 count of three
    do_rep(3); do_arm(1);
    for (int k = 0; k < 3; k++) begin
      tick1();
      chk(alarm_pulse == 1, "R5 repeat fires", alarm_pulse, 1);
      chk(rep_left == 2 - k, "R5 decrement", rep_left, 2 - k);
      chk(armed == 1, "R5 stays armed", armed, 1);
    end
    tick1();
    chk(alarm_pulse == 1 && armed == 0, "R6 last shot disarms", armed, 0);

    // R6 FFh yields 256 events
    do_rep(8'hFF); do_arm(1);
    n = 0;
    @(negedge clk); half_tick = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (alarm_pulse) n++;
      if (!armed) break;
    end
    half_tick = 0;
    chk(n == 256, "R6 full run event count", n, 256);

    // R7 chime wrap, R11 chime write while armed
    do_chime(1); do_rep(1); do_arm(1);
    tick1(); chk(rep_left == 0, "R7 count to zero", rep_left, 0);
    tick1(); chk(rep_left == 8'hFF && armed == 1, "R7 wrap to FF", rep_left, 255);
    tick1(); chk(rep_left == 8'hFE, "R7 continues", rep_left, 254);
    do_chime(0); do_rep(0);
    chk(rep_left == 0, "R8 load while armed", rep_left, 0);
    tick1(); chk(armed == 0, "R11 chime off while armed", armed, 0);

    // R11 chime write in event cycle: old chime (off) applies
    do_rep(0); do_arm(1);
    @(negedge clk); half_tick = 1; chime_val = 1; chime_wr = 1;
    @(negedge clk); half_tick = 0; chime_wr = 0;
    chk(armed == 0, "R11 old chime used", armed, 0);

    // R8 load beats decrement
    do_rep(5); do_arm(1);
    @(negedge clk); half_tick = 1; rep_val = 9; rep_wr = 1;
    @(negedge clk); half_tick = 0; rep_wr = 0;
    chk(alarm_pulse == 1, "R8 event still fires", alarm_pulse, 1);
    chk(rep_left == 9, "R8 load priority", rep_left, 9);

    // R10 arm write beats auto disarm
    do_chime(0); do_rep(0);
    @(negedge clk); half_tick = 1; arm_val = 1; arm_wr = 1;
    @(negedge clk); half_tick = 0; arm_wr = 0;
    chk(alarm_pulse == 1 && armed == 1, "R10 arm write priority", armed, 1);
    do_arm(0);
    chk(armed == 0, "R10 disarm write", armed, 0);

    // R9 setting locked while armed
    do_set(0, 8'h10, 0, 0, 0, 0, 0, 4'd3);
    do_rep(8'h20); do_arm(1);
    do_set(0, 8'h20, 0, 0, 0, 0, 0, 4'd3);
    do_now(0, 8'h20, 0, 0, 0, 0, 0);
    tick1(); chk(alarm_pulse == 0, "R9 locked write ignored", alarm_pulse, 0);
    do_now(0, 8'h10, 0, 0, 0, 0, 0);
    tick1(); chk(alarm_pulse == 1, "R9 old setting kept", alarm_pulse, 1);
    do_arm(0);
    do_set(0, 8'h20, 0, 0, 0, 0, 0, 4'd3);
    do_arm(1);
    do_now(0, 8'h20, 0, 0, 0, 0, 0);
    tick1(); chk(alarm_pulse == 1, "R9 write accepted when disarmed", alarm_pulse, 1);

    repeat (3) cyc();
    finish_run();
  end

endmodule